// File: doc/BRIEF.md
# Read-After-Write Interlock for a Five-Stage Pipeline

This block decides, every cycle, whether the instruction waiting in decode may move on to execute. The pipeline it serves has no bypass network, so an instruction that reads a register must wait until every older instruction that writes that register has left the stages where its result is not yet in the register file. The block decodes the opcode of the decode-stage word to learn which fixed-position register fields are read and which one is written. It compares the sources against the destination held in its own decode/execute control register and against the destinations of the later stages that the pipeline hands in.

On a match the block drops the PC and fetch/decode write enables, so the front end holds its instruction. In the same cycle it loads a bubble into the decode/execute control register: no register write, no memory access, destination zero. The register file writes early in the cycle and reads late, so the writeback stage is never compared. The execute-stage destination, write enable and memory enable that this block registers are the ones the rest of the pipeline carries forward.

Top module: `raw_interlock`

## Requirements
- R1: After reset the decode/execute control register holds no register write, no memory enable and destination 0, and with an all-zero decode word no stall is raised.
- R2: Opcode 0 (register-register format) reads the registers in bits 25:21 and 20:16 and writes the register in bits 15:11. When issued, the next cycle shows exRegWrite=1, exMemEn=0, exDest = bits 15:11.
- R3: Any opcode not listed in R2, R4 or R5 is register-immediate format. It reads only bits 25:21 and writes bits 20:16, so a match on bits 20:16 alone does not stall.
- R4: Opcode 0x23 (load) reads bits 25:21, writes bits 20:16 and sets exMemEn. Opcode 0x2B (store) reads bits 25:21 and 20:16, sets exMemEn, writes no register, and is registered with destination 0.
- R5: Opcodes 0x04 and 0x05 (branch) read only bits 25:21 and write nothing. Opcodes 0x02 and 0x03 (jump) read and write nothing and never stall.
- R6: A read source equal to the destination in the decode/execute control register, with its write enable set, raises stall in the same cycle.
- R7: A read source equal to a later-stage destination whose write enable is set raises stall in the same cycle.
- R8: Register 0 never matches, even with write enables set.
- R9: A destination whose write enable is clear never causes a stall.
- R10: While stall is high, pcWrite and ifIdWrite are 0. At the next clock edge the decode/execute control register takes a bubble: exRegWrite=0, exMemEn=0, exDest=0.
- R11: A reader directly behind its producer stalls two cycles. With one instruction between them it stalls one cycle. With two between it does not stall, because the writeback stage is not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idInstr | input | 32 | Instruction word held in decode |
| lateDest | input | 5*LATE_STAGES | Destination registers of the compared stages after execute |
| lateWe | input | LATE_STAGES | Register-write enables of those stages |
| stall | output | 1 | Decode instruction must wait this cycle |
| pcWrite | output | 1 | PC may update |
| ifIdWrite | output | 1 | Fetch/decode register may update |
| exDest | output | 5 | Destination register in the decode/execute control register |
| exRegWrite | output | 1 | Register-write enable in the decode/execute control register |
| exMemEn | output | 1 | Memory enable in the decode/execute control register |

## Verification
The hardest case to reach from the ports is the stall whose length depends on how far the producer is ahead. That needs a producer to travel out of the block's own execute register into the later stage while the reader is held in decode. The bench models the memory stage as a register fed from exDest and exRegWrite. It holds the decode word while stall is high, and counts stall cycles for producers zero, one and two instructions ahead. Format checks place a live destination on a field the format does not read, so a wrong field choice shows as a spurious or missing stall.

// File: rtl/rawlk_pkg.sv
package rawlk_pkg;

  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int REG_AW  = 5;

  localparam logic [OP_W-1:0] OPC_REGREG = 6'h00;
  localparam logic [OP_W-1:0] OPC_JUMP   = 6'h02;
  localparam logic [OP_W-1:0] OPC_JLINK  = 6'h03;
  localparam logic [OP_W-1:0] OPC_BRZ    = 6'h04;
  localparam logic [OP_W-1:0] OPC_BRNZ   = 6'h05;
  localparam logic [OP_W-1:0] OPC_LOAD   = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE  = 6'h2B;

  typedef enum logic [2:0] {
    FMT_REGREG,
    FMT_REGIMM,
    FMT_LOAD,
    FMT_STORE,
    FMT_BRANCH,
    FMT_JUMP
  } fmt_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic useSrcA;
    logic useSrcB;
    logic destFromRd;
    logic regWrite;
    logic memEn;
    logic bubble;
  } strobe_t;

endpackage

// File: rtl/rawlk_cmp.sv
module rawlk_cmp #(
  parameter int REG_AW = rawlk_pkg::REG_AW
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dest,
  input  logic              destWe,
  output logic              hit
);

  logic destLive;

  // Register 0 is hardwired to zero and never carries a dependence.
  assign destLive = destWe && (dest != '0);
  assign hit      = destLive && (dest == src);

endmodule

// File: rtl/rawlk_dpath.sv
module rawlk_dpath
  import rawlk_pkg::*;
#(
  parameter int INSTR_W     = rawlk_pkg::INSTR_W,
  parameter int OP_W        = rawlk_pkg::OP_W,
  parameter int REG_AW      = rawlk_pkg::REG_AW,
  parameter int LATE_STAGES = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [INSTR_W-1:0]            idInstr,
  input  logic [LATE_STAGES*REG_AW-1:0] lateDest,
  input  logic [LATE_STAGES-1:0]        lateWe,
  input  strobe_t                       strobes,
  output logic                          srcAHit,
  output logic                          srcBHit,
  output logic [REG_AW-1:0]             exDest,
  output logic                          exRegWrite,
  output logic                          exMemEn
);

  localparam int OP_LSB   = INSTR_W - OP_W;
  localparam int SRCA_LSB = OP_LSB - REG_AW;
  localparam int SRCB_LSB = SRCA_LSB - REG_AW;
  localparam int RD_LSB   = SRCB_LSB - REG_AW;
  localparam int STAGES   = LATE_STAGES + 1;

  logic [REG_AW-1:0] srcA;
  logic [REG_AW-1:0] srcB;
  logic [REG_AW-1:0] fieldRd;
  logic [REG_AW-1:0] idDest;

  logic [REG_AW-1:0] stageDest [STAGES];
  logic              stageWe   [STAGES];
  logic [STAGES-1:0] hitA;
  logic [STAGES-1:0] hitB;

  logic [REG_AW-1:0] exDestQ;
  logic              exRegWriteQ;
  logic              exMemEnQ;
  logic              issueWrite;

  assign srcA    = idInstr[SRCA_LSB +: REG_AW];
  assign srcB    = idInstr[SRCB_LSB +: REG_AW];
  assign fieldRd = idInstr[RD_LSB +: REG_AW];
  assign idDest  = strobes.destFromRd ? fieldRd : srcB;

  // Stage 0 is the execute slot held here; the rest arrive from outside.
  assign stageDest[0] = exDestQ;
  assign stageWe[0]   = exRegWriteQ;

  for (genvar s = 1; s < STAGES; s++) begin : g_late
    assign stageDest[s] = lateDest[(s-1)*REG_AW +: REG_AW];
    assign stageWe[s]   = lateWe[s-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_cmp
    rawlk_cmp #(.REG_AW(REG_AW)) u_cmpA (
      .src    (srcA),
      .dest   (stageDest[s]),
      .destWe (stageWe[s]),
      .hit    (hitA[s])
    );
    rawlk_cmp #(.REG_AW(REG_AW)) u_cmpB (
      .src    (srcB),
      .dest   (stageDest[s]),
      .destWe (stageWe[s]),
      .hit    (hitB[s])
    );
  end

  assign srcAHit = |hitA;
  assign srcBHit = |hitB;

  assign issueWrite = strobes.regWrite && !strobes.bubble;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exDestQ     <= '0;
      exRegWriteQ <= 1'b0;
      exMemEnQ    <= 1'b0;
    end else begin
      exRegWriteQ <= issueWrite;
      exMemEnQ    <= strobes.memEn && !strobes.bubble;
      exDestQ     <= issueWrite ? idDest : '0;
    end
  end

  assign exDest     = exDestQ;
  assign exRegWrite = exRegWriteQ;
  assign exMemEn    = exMemEnQ;

  // Opcode and immediate bits are decoded by control, not here.
  logic unusedBits;
  assign unusedBits = ^{idInstr[INSTR_W-1:SRCA_LSB+REG_AW], idInstr[RD_LSB-1:0]};

endmodule

// File: rtl/rawlk_ctrl.sv
module rawlk_ctrl
  import rawlk_pkg::*;
#(
  parameter int OP_W = rawlk_pkg::OP_W
) (
  input  logic [OP_W-1:0] opcode,
  input  logic            srcAHit,
  input  logic            srcBHit,
  output strobe_t         strobes,
  output logic            stall
);

  fmt_e fmt;
  logic hazard;

  always_comb begin
    unique case (opcode)
      OPC_REGREG:          fmt = FMT_REGREG;
      OPC_LOAD:            fmt = FMT_LOAD;
      OPC_STORE:           fmt = FMT_STORE;
      OPC_BRZ, OPC_BRNZ:   fmt = FMT_BRANCH;
      OPC_JUMP, OPC_JLINK: fmt = FMT_JUMP;
      default:             fmt = FMT_REGIMM;
    endcase
  end

  always_comb begin
    strobes = '0;
    unique case (fmt)
      FMT_REGREG: begin
        strobes.useSrcA    = 1'b1;
        strobes.useSrcB    = 1'b1;
        strobes.destFromRd = 1'b1;
        strobes.regWrite   = 1'b1;
      end
      FMT_REGIMM: begin
        strobes.useSrcA  = 1'b1;
        strobes.regWrite = 1'b1;
      end
      FMT_LOAD: begin
        strobes.useSrcA  = 1'b1;
        strobes.regWrite = 1'b1;
        strobes.memEn    = 1'b1;
      end
      FMT_STORE: begin
        strobes.useSrcA = 1'b1;
        strobes.useSrcB = 1'b1;
        strobes.memEn   = 1'b1;
      end
      FMT_BRANCH: begin
        strobes.useSrcA = 1'b1;
      end
      default: begin
        // Jump: no register fields compared, nothing written.
      end
    endcase
    hazard         = (strobes.useSrcA && srcAHit) || (strobes.useSrcB && srcBHit);
    strobes.bubble = hazard;
  end

  assign stall = hazard;

endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
  import rawlk_pkg::*;
#(
  parameter int INSTR_W     = rawlk_pkg::INSTR_W,
  parameter int OP_W        = rawlk_pkg::OP_W,
  parameter int REG_AW      = rawlk_pkg::REG_AW,
  parameter int LATE_STAGES = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [INSTR_W-1:0]            idInstr,
  input  logic [LATE_STAGES*REG_AW-1:0] lateDest,
  input  logic [LATE_STAGES-1:0]        lateWe,
  output logic                          stall,
  output logic                          pcWrite,
  output logic                          ifIdWrite,
  output logic [REG_AW-1:0]             exDest,
  output logic                          exRegWrite,
  output logic                          exMemEn
);

  strobe_t strobes;
  logic    srcAHit;
  logic    srcBHit;
  logic    stallInt;

  rawlk_ctrl #(.OP_W(OP_W)) u_ctrl (
    .opcode  (idInstr[INSTR_W-1 -: OP_W]),
    .srcAHit (srcAHit),
    .srcBHit (srcBHit),
    .strobes (strobes),
    .stall   (stallInt)
  );

  rawlk_dpath #(
    .INSTR_W     (INSTR_W),
    .OP_W        (OP_W),
    .REG_AW      (REG_AW),
    .LATE_STAGES (LATE_STAGES)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .idInstr    (idInstr),
    .lateDest   (lateDest),
    .lateWe     (lateWe),
    .strobes    (strobes),
    .srcAHit    (srcAHit),
    .srcBHit    (srcBHit),
    .exDest     (exDest),
    .exRegWrite (exRegWrite),
    .exMemEn    (exMemEn)
  );

  assign stall     = stallInt;
  assign pcWrite   = !stallInt;
  assign ifIdWrite = !stallInt;

endmodule

// File: rtl/raw_interlock_chk.sv
module raw_interlock_chk #(
  parameter int OP_W        = rawlk_pkg::OP_W,
  parameter int REG_AW      = rawlk_pkg::REG_AW,
  parameter int LATE_STAGES = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [OP_W-1:0]        idOp,
  input logic [REG_AW-1:0]      idSrcA,
  input logic [REG_AW-1:0]      idSrcB,
  input logic [LATE_STAGES-1:0] lateWe,
  input logic                   stall,
  input logic                   pcWrite,
  input logic                   ifIdWrite,
  input logic [REG_AW-1:0]      exDest,
  input logic                   exRegWrite,
  input logic                   exMemEn
);

  assert_jump_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idOp == 6'h02 || idOp == 6'h03) |-> !stall);

  assert_ex_match_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idOp == 6'h00 && exRegWrite && exDest != '0 && exDest == idSrcA) |-> stall);

  assert_zero_reg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idSrcA == '0 && idSrcB == '0) |-> !stall);

  assert_no_writers_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!exRegWrite && lateWe == '0) |-> !stall);

  assert_front_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pcWrite && !ifIdWrite));

  assert_bubble_loaded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!exRegWrite && !exMemEn && exDest == '0));

endmodule

bind raw_interlock raw_interlock_chk #(
  .OP_W(OP_W), .REG_AW(REG_AW), .LATE_STAGES(LATE_STAGES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idOp       (idInstr[INSTR_W-1 -: OP_W]),
  .idSrcA     (idInstr[INSTR_W-OP_W-1 -: REG_AW]),
  .idSrcB     (idInstr[INSTR_W-OP_W-REG_AW-1 -: REG_AW]),
  .lateWe     (lateWe),
  .stall      (stall),
  .pcWrite    (pcWrite),
  .ifIdWrite  (ifIdWrite),
  .exDest     (exDest),
  .exRegWrite (exRegWrite),
  .exMemEn    (exMemEn)
);

// File: tb/raw_interlock_tb.sv
`timescale 1ns/1ps
module raw_interlock_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] idInstr = '0;
  logic [4:0]  lateDest;
  logic [0:0]  lateWe;
  logic        stall, pcWrite, ifIdWrite, exRegWrite, exMemEn;
  logic [4:0]  exDest;

  logic        autoMode = 1'b0;
  logic [4:0]  manDest = '0;
  logic        manWe = 1'b0;
  logic [4:0]  pipeDest;
  logic        pipeWe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Memory-stage model: takes what leaves execute.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipeDest <= '0;
      pipeWe   <= 1'b0;
    end else begin
      pipeDest <= exDest;
      pipeWe   <= exRegWrite;
    end
  end

  assign lateDest = autoMode ? pipeDest : manDest;
  assign lateWe   = autoMode ? pipeWe : manWe;

  raw_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .idInstr(idInstr),
    .lateDest(lateDest), .lateWe(lateWe),
    .stall(stall), .pcWrite(pcWrite), .ifIdWrite(ifIdWrite),
    .exDest(exDest), .exRegWrite(exRegWrite), .exMemEn(exMemEn)
  );

  function automatic logic [31:0] rr(input logic [4:0] a, b, d);
    return {6'h00, a, b, d, 11'd0};
  endfunction
  function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] a, b);
    return {op, a, b, 16'h0040};
  endfunction
  localparam logic [31:0] JMP = {6'h02, 26'h155_5555};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Put a word into decode, let logic settle (just after a falling edge).
  task automatic present(input logic [31:0] w);
    idInstr = w;
    #1;
  endtask

  // Let the current decode word be taken at the next rising edge.
  task automatic advance();
    @(negedge clk);
  endtask

  task automatic flush();
    present(JMP); advance();
    present(JMP); advance();
  endtask

  task automatic stallCount(input logic [31:0] w, output int n);
    n = 0;
    present(w);
    for (int i = 0; i < 6; i++) begin
      if (!stall) break;
      n++;
      advance();
      #1;
    end
  endtask

  task automatic test_reset();
    present('0);
    chk("R1 exRegWrite", exRegWrite, 0);
    chk("R1 exMemEn", exMemEn, 0);
    chk("R1 exDest", exDest, 0);
    chk("R1 stall", stall, 0);
  endtask

  task automatic test_formats();
    autoMode = 0; manWe = 0; flush();
    present(rr(5'd1, 5'd2, 5'd7)); advance(); #1;
    chk("R2 dest", exDest, 7);
    chk("R2 write", exRegWrite, 1);
    chk("R2 mem", exMemEn, 0);
    flush();
    manDest = 5'd9; manWe = 1;
    present(rr(5'd1, 5'd9, 5'd3));
    chk("R2 srcB read / R7 late match", stall, 1);
    present(ri(6'h08, 5'd1, 5'd9));
    chk("R3 bits20:16 not read", stall, 0);
    advance(); #1;
    chk("R3 dest from 20:16", exDest, 9);
    chk("R3 write", exRegWrite, 1);
    present(JMP); advance();
    present(ri(6'h08, 5'd9, 5'd2));
    chk("R3 srcA read", stall, 1);
    manWe = 0;
    present(ri(6'h23, 5'd1, 5'd4)); advance(); #1;
    chk("R4 load dest", exDest, 4);
    chk("R4 load write", exRegWrite, 1);
    chk("R4 load mem", exMemEn, 1);
    present(JMP); advance();
    manWe = 1;
    present(ri(6'h2B, 5'd1, 5'd9));
    chk("R4 store reads 20:16", stall, 1);
    manWe = 0;
    present(ri(6'h2B, 5'd1, 5'd9)); advance(); #1;
    chk("R4 store no write", exRegWrite, 0);
    chk("R4 store mem", exMemEn, 1);
    chk("R4 store dest", exDest, 0);
    present(JMP); advance();
    manWe = 1;
    present(ri(6'h04, 5'd1, 5'd9));
    chk("R5 branch ignores 20:16", stall, 0);
    present(ri(6'h05, 5'd9, 5'd1));
    chk("R5 branch reads 25:21", stall, 1);
    present({6'h03, 5'd9, 5'd9, 16'd0});
    chk("R5 jump no compare", stall, 0);
    advance(); #1;
    chk("R5 jump no write", exRegWrite, 0);
    chk("R5 jump no mem", exMemEn, 0);
  endtask

  task automatic test_filters();
    autoMode = 0; flush();
    manDest = 5'd0; manWe = 1;
    present(rr(5'd0, 5'd0, 5'd6));
    chk("R8 r0 never matches", stall, 0);
    manDest = 5'd9; manWe = 0;
    present(rr(5'd9, 5'd9, 5'd6));
    chk("R9 disabled writer", stall, 0);
    advance();
    present(rr(5'd0, 5'd0, 5'd3));
    chk("R8 r0 vs execute", stall, 0);
  endtask

  task automatic test_distance();
    int n;
    autoMode = 1; flush();
    present(rr(5'd1, 5'd2, 5'd3)); advance();
    present(rr(5'd3, 5'd4, 5'd5));
    chk("R6 execute match", stall, 1);
    chk("R10 pcWrite", pcWrite, 0);
    chk("R10 ifIdWrite", ifIdWrite, 0);
    advance(); #1;
    chk("R10 bubble write", exRegWrite, 0);
    chk("R10 bubble mem", exMemEn, 0);
    chk("R10 bubble dest", exDest, 0);
    chk("R7 memory-stage match", stall, 1);
    stallCount(rr(5'd3, 5'd4, 5'd5), n);
    chk("R11 adjacent remaining stalls", n, 1);
    advance(); #1;
    chk("R11 reader issued dest", exDest, 5);
    chk("R11 reader issued write", exRegWrite, 1);
    flush();
    present(ri(6'h23, 5'd1, 5'd6)); advance();
    present(rr(5'd1, 5'd2, 5'd8)); advance();
    stallCount(rr(5'd7, 5'd6, 5'd10), n);
    chk("R11 one between", n, 1);
    advance();
    flush();
    present(rr(5'd1, 5'd2, 5'd11)); advance();
    present(JMP); advance();
    present(JMP); advance();
    stallCount(rr(5'd11, 5'd11, 5'd12), n);
    chk("R11 writeback not compared", n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    test_reset();
    test_formats();
    test_filters();
    test_distance();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule